// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block sits beside a small CPU core and decides which of five interrupt sources is serviced next. The sources are two external request pins, two timer overflow events and one serial port. A global enable bit gates every source, and each source also has an enable bit of its own. A priority bit per source places it at the high or the low level. When an enabled request is pending and the nesting rules allow it, the block emits a one-cycle vector strobe with the routine's start address. In the same cycle it records the serviced level as active and clears any request flag that hardware owns.

Nesting has two levels. A high-level request may interrupt a low-level routine. A request at the same level as a running routine, or below it, waits. The CPU sends a one-cycle return pulse when a routine ends, and the pulse releases the highest active level. Each external pin is active low. A type bit chooses between latching the request on a falling edge and following the pin level. The CPU's stack handling is outside this block.

Top module: `irqPrioCtrl`

## Requirements
- R1: After reset `vecStrobe`, `vecAddr`, `activeLvl` and `pendFlags` are all zero.
- R2: While `globalEn` is low, no vector strobe is issued, and pending flags are kept.
- R3: A source whose `srcEn` bit is low is never vectored, and its flag stays pending.
- R4: When several enabled requests are pending at one level, the source served first is the one earliest in this order: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. The same bit indices are used in `srcEn`, `srcHigh` and `pendFlags`.
- R5: The vector address is 0x0003 + 8 × source index, which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. It appears one cycle after the flag is visible, with `vecStrobe` high for that one cycle, and `vecAddr` holds the value until the next strobe.
- R6: A high-priority request (`srcHigh` bit = 1) is vectored while only the low level is active. Afterwards `activeLvl` = 2'b11, where bit 1 marks the high level and bit 0 the low level.
- R7: A low-priority request is not vectored while any level is active. A high-priority request is not vectored while the high level is active.
- R8: Vectoring sets the `activeLvl` bit for the level that was served. A return pulse clears bit 1 if it is set, and otherwise clears bit 0.
- R9: With its type bit at 1, an external flag is set on a falling pin edge, stays set until it is vectored, and is cleared by the vectoring.
- R10: With its type bit at 0, an external flag equals the inverted pin, delayed by one register, and vectoring does not clear it.
- R11: A one-cycle overflow pulse sets a timer flag, which is cleared when that timer is vectored. A new pulse in the same cycle wins over the clear.
- R12: The serial flag is the registered OR of `rxDone` and `txDone`, and vectoring does not clear it.
- R13: In a cycle where `retPulse` is high, no new vector is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Master enable for all sources |
| srcEn | input | 5 | Per-source enable |
| srcHigh | input | 5 | Per-source level, 1 = high |
| ext0Pin | input | 1 | External request 0, active low |
| ext1Pin | input | 1 | External request 1, active low |
| ext0Edge | input | 1 | 1 = falling-edge capture, 0 = level for external 0 |
| ext1Edge | input | 1 | 1 = falling-edge capture, 0 = level for external 1 |
| tmr0Ovf | input | 1 | Timer 0 overflow pulse |
| tmr1Ovf | input | 1 | Timer 1 overflow pulse |
| rxDone | input | 1 | Serial receive finished |
| txDone | input | 1 | Serial transmit finished |
| retPulse | input | 1 | Return-from-interrupt pulse |
| vecStrobe | output | 1 | One-cycle vector issue strobe |
| vecAddr | output | 16 | Vector address of the last issued interrupt |
| activeLvl | output | 2 | Active levels, bit 1 high, bit 0 low |
| pendFlags | output | 5 | Pending request flags |

## Verification
Directed sequences cover the following cases:
- All five flags raised at once, to show the polling order and each vector address.
- A low routine interrupted by a high request while a second low request waits, which separates preemption from queuing and shows that a return releases the higher level first.
- Sources that are masked, globally or one at a time, which shows that a flag is kept without being served.
- Edge mode against level mode on one pin, which shows latching and clearing on one side and pin-following on the other.

Seeded random traffic then mixes every input together, including return pulses that arrive while a request is pending. A cycle model in the bench predicts the strobe, address, levels and flags for each cycle.

// File: rtl/irqPrioPkg.sv
package irqPrioPkg;
  localparam int NUM_SRC  = 5;
  localparam int VEC_W    = 16;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;
  localparam int NUM_EXT  = 2;
  localparam int LVL_W    = 2;

  typedef struct packed {
    logic               fire;
    logic               hiLevel;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] clr;
  } irqStrobeT;

  function automatic logic [NUM_SRC-1:0] lowestSet(input logic [NUM_SRC-1:0] v);
    logic [NUM_SRC-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (v[i] && (r == '0)) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] vecOf(input int idx);
    return VEC_W'(VEC_BASE + VEC_STEP * idx);
  endfunction
endpackage

// File: rtl/irqPrioCtrl_ctrl.sv
module irqPrioCtrl_ctrl
  import irqPrioPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalEn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcHigh,
  input  logic               ext0Edge,
  input  logic               ext1Edge,
  input  logic               retPulse,
  input  logic [NUM_SRC-1:0] pendFlags,
  output irqStrobeT          strobe,
  output logic [LVL_W-1:0]   activeLvl
);
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] candHi;
  logic [NUM_SRC-1:0] candLo;
  logic [NUM_SRC-1:0] hwClr;
  logic [NUM_SRC-1:0] grant;

  always_comb begin
    cand   = pendFlags & srcEn & {NUM_SRC{globalEn}};
    candHi = cand & srcHigh;
    candLo = cand & ~srcHigh;
    grant  = '0;
    if (!retPulse) begin
      if ((candHi != '0) && !activeLvl[1])
        grant = lowestSet(candHi);
      else if ((candLo != '0) && (activeLvl == '0))
        grant = lowestSet(candLo);
    end
    hwClr          = {1'b0, 1'b1, ext1Edge, 1'b1, ext0Edge};
    strobe.fire    = |grant;
    strobe.hiLevel = |(grant & srcHigh);
    strobe.grant   = grant;
    strobe.clr     = grant & hwClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeLvl <= '0;
    end else if (retPulse) begin
      if (activeLvl[1]) activeLvl[1] <= 1'b0;
      else              activeLvl[0] <= 1'b0;
    end else if (strobe.fire) begin
      if (strobe.hiLevel) activeLvl[1] <= 1'b1;
      else                activeLvl[0] <= 1'b1;
    end
  end
endmodule

// File: rtl/irqPrioCtrl_dp.sv
module irqPrioCtrl_dp
  import irqPrioPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ext0Pin,
  input  logic               ext1Pin,
  input  logic               ext0Edge,
  input  logic               ext1Edge,
  input  logic               tmr0Ovf,
  input  logic               tmr1Ovf,
  input  logic               rxDone,
  input  logic               txDone,
  input  irqStrobeT          strobe,
  output logic [NUM_SRC-1:0] pendFlags,
  output logic               vecStrobe,
  output logic [VEC_W-1:0]   vecAddr
);
  logic [NUM_EXT-1:0] extPin;
  logic [NUM_EXT-1:0] extEdge;
  logic [NUM_EXT-1:0] tmrOvf;
  logic [NUM_EXT-1:0] pinPrev;
  logic [NUM_SRC-1:0] flagsNext;
  logic [VEC_W-1:0]   vecNext;

  assign extPin  = {ext1Pin, ext0Pin};
  assign extEdge = {ext1Edge, ext0Edge};
  assign tmrOvf  = {tmr1Ovf, tmr0Ovf};

  always_comb begin
    flagsNext = pendFlags;
    for (int g = 0; g < NUM_EXT; g++) begin
      if (extEdge[g])
        flagsNext[2*g] = (pendFlags[2*g] & ~strobe.clr[2*g]) | (pinPrev[g] & ~extPin[g]);
      else
        flagsNext[2*g] = ~extPin[g];
      flagsNext[2*g+1] = (pendFlags[2*g+1] & ~strobe.clr[2*g+1]) | tmrOvf[g];
    end
    flagsNext[NUM_SRC-1] = rxDone | txDone;
  end

  always_comb begin
    vecNext = vecAddr;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strobe.grant[i]) vecNext = vecOf(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPrev   <= '1;
      pendFlags <= '0;
      vecStrobe <= 1'b0;
      vecAddr   <= '0;
    end else begin
      pinPrev   <= extPin;
      pendFlags <= flagsNext;
      vecStrobe <= strobe.fire;
      vecAddr   <= vecNext;
    end
  end
endmodule

// File: rtl/irqPrioCtrl.sv
module irqPrioCtrl
  import irqPrioPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        globalEn,
  input  logic [4:0]  srcEn,
  input  logic [4:0]  srcHigh,
  input  logic        ext0Pin,
  input  logic        ext1Pin,
  input  logic        ext0Edge,
  input  logic        ext1Edge,
  input  logic        tmr0Ovf,
  input  logic        tmr1Ovf,
  input  logic        rxDone,
  input  logic        txDone,
  input  logic        retPulse,
  output logic        vecStrobe,
  output logic [15:0] vecAddr,
  output logic [1:0]  activeLvl,
  output logic [4:0]  pendFlags
);
  irqStrobeT strobe;

  irqPrioCtrl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .srcEn(srcEn), .srcHigh(srcHigh),
    .ext0Edge(ext0Edge), .ext1Edge(ext1Edge), .retPulse(retPulse),
    .pendFlags(pendFlags), .strobe(strobe), .activeLvl(activeLvl)
  );

  irqPrioCtrl_dp dp_i (
    .clk(clk), .rstN(rstN), .ext0Pin(ext0Pin), .ext1Pin(ext1Pin),
    .ext0Edge(ext0Edge), .ext1Edge(ext1Edge), .tmr0Ovf(tmr0Ovf), .tmr1Ovf(tmr1Ovf),
    .rxDone(rxDone), .txDone(txDone), .strobe(strobe),
    .pendFlags(pendFlags), .vecStrobe(vecStrobe), .vecAddr(vecAddr)
  );
endmodule

// File: rtl/irqPrioCtrl_chk.sv
module irqPrioCtrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        globalEn,
  input logic        retPulse,
  input logic        tmr0Ovf,
  input logic        vecStrobe,
  input logic [15:0] vecAddr,
  input logic [1:0]  activeLvl,
  input logic [4:0]  pendFlags
);
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> !vecStrobe); // R2
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    vecStrobe |-> (vecAddr[2:0] == 3'd3 && vecAddr <= 16'h0023)); // R5
  AST_ENTRY_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    vecStrobe |-> activeLvl != 2'b00); // R6
  AST_NEST_ONLY_UP: assert property (@(posedge clk) disable iff (!rstN)
    (vecStrobe && $past(activeLvl) != 2'b00) |-> ($past(activeLvl) == 2'b01 && activeLvl == 2'b11)); // R7
  AST_RET_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (retPulse && activeLvl == 2'b11) |=> activeLvl == 2'b01); // R8
  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (vecStrobe && vecAddr == 16'h000B && !$past(tmr0Ovf)) |-> !pendFlags[1]); // R11
  AST_RET_NO_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    retPulse |=> !vecStrobe); // R13
endmodule

bind irqPrioCtrl irqPrioCtrl_chk chk_i (
  .clk(clk), .rstN(rstN), .globalEn(globalEn), .retPulse(retPulse), .tmr0Ovf(tmr0Ovf),
  .vecStrobe(vecStrobe), .vecAddr(vecAddr), .activeLvl(activeLvl), .pendFlags(pendFlags)
);

// File: tb/irqPrioCtrl_tb_top.sv
module irqPrioCtrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic globalEn, ext0Pin, ext1Pin, ext0Edge, ext1Edge, tmr0Ovf, tmr1Ovf, rxDone, txDone, retPulse;
  logic [4:0] srcEn, srcHigh;
  logic vecStrobe;
  logic [15:0] vecAddr;
  logic [1:0] activeLvl;
  logic [4:0] pendFlags;

  int checks = 0;
  int failures = 0;

  logic [4:0]  mFlags;
  logic [1:0]  mAct;
  logic [1:0]  mPrev;
  logic        mStrobe;
  logic [15:0] mAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqPrioCtrl dut_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .srcEn(srcEn), .srcHigh(srcHigh),
    .ext0Pin(ext0Pin), .ext1Pin(ext1Pin), .ext0Edge(ext0Edge), .ext1Edge(ext1Edge),
    .tmr0Ovf(tmr0Ovf), .tmr1Ovf(tmr1Ovf), .rxDone(rxDone), .txDone(txDone),
    .retPulse(retPulse), .vecStrobe(vecStrobe), .vecAddr(vecAddr),
    .activeLvl(activeLvl), .pendFlags(pendFlags)
  );

  function automatic logic [4:0] firstBit(input logic [4:0] v);
    for (int i = 0; i < 5; i++) if (v[i]) return 5'(1 << i);
    return 5'd0;
  endfunction

  function automatic int bitIdx(input logic [4:0] v);
    for (int i = 0; i < 5; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    logic [4:0] cand, hi, lo, grant, clr, nf;
    cand = mFlags & srcEn & {5{globalEn}};
    hi = cand & srcHigh;
    lo = cand & ~srcHigh;
    grant = 5'd0;
    if (!retPulse) begin
      if (hi != 0 && !mAct[1]) grant = firstBit(hi);
      else if (lo != 0 && mAct == 2'b00) grant = firstBit(lo);
    end
    clr = grant & {1'b0, 1'b1, ext1Edge, 1'b1, ext0Edge};
    nf[0] = ext0Edge ? ((mFlags[0] & ~clr[0]) | (mPrev[0] & ~ext0Pin)) : ~ext0Pin;
    nf[2] = ext1Edge ? ((mFlags[2] & ~clr[2]) | (mPrev[1] & ~ext1Pin)) : ~ext1Pin;
    nf[1] = (mFlags[1] & ~clr[1]) | tmr0Ovf;
    nf[3] = (mFlags[3] & ~clr[3]) | tmr1Ovf;
    nf[4] = rxDone | txDone;
    if (retPulse) begin
      if (mAct[1]) mAct[1] = 1'b0; else mAct[0] = 1'b0;
    end else if (grant != 0) begin
      if ((grant & srcHigh) != 0) mAct[1] = 1'b1; else mAct[0] = 1'b1;
    end
    mStrobe = (grant != 0);
    if (grant != 0) mAddr = 16'(3 + 8 * bitIdx(grant));
    mPrev = {ext1Pin, ext0Pin};
    mFlags = nf;
  endtask

  task automatic cycle();
    modelStep();
    @(negedge clk);
    chk("R4 strobe vs model", 32'(vecStrobe), 32'(mStrobe));
    chk("R5 vector vs model", 32'(vecAddr), 32'(mAddr));
    chk("R8 levels vs model", 32'(activeLvl), 32'(mAct));
    chk("R9 flags vs model", 32'(pendFlags), 32'(mFlags));
  endtask

  task automatic setIdle();
    globalEn = 1'b1; srcEn = 5'h1F; srcHigh = 5'h00;
    ext0Pin = 1'b1; ext1Pin = 1'b1; ext0Edge = 1'b1; ext1Edge = 1'b1;
    tmr0Ovf = 1'b0; tmr1Ovf = 1'b0; rxDone = 1'b0; txDone = 1'b0; retPulse = 1'b0;
  endtask

  task automatic settle();
    setIdle();
    globalEn = 1'b0;
    retPulse = 1'b1;
    cycle(); cycle();
    retPulse = 1'b0;
    cycle();
  endtask

  task automatic retOnce();
    retPulse = 1'b1; cycle(); retPulse = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    setIdle();
    mFlags = 0; mAct = 0; mPrev = 2'b11; mStrobe = 0; mAddr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset strobe", 32'(vecStrobe), 0);
    chk("R1 reset vector", 32'(vecAddr), 0);
    chk("R1 reset levels", 32'(activeLvl), 0);
    chk("R1 reset flags", 32'(pendFlags), 0);

    // R2 and R11: global gate, timer flag set and cleared
    globalEn = 1'b0; tmr0Ovf = 1'b1; cycle(); tmr0Ovf = 1'b0; cycle();
    chk("R2 no vector while globally off", 32'(vecStrobe), 0);
    chk("R11 timer flag set", 32'(pendFlags[1]), 1);
    globalEn = 1'b1; cycle();
    chk("R5 timer0 vector", 32'(vecAddr), 32'h000B);
    chk("R11 timer flag cleared", 32'(pendFlags[1]), 0);
    chk("R8 entry sets low level", 32'(activeLvl), 1);
    retOnce();
    chk("R8 return clears low level", 32'(activeLvl), 0);

    // R4: all five at once
    settle();
    ext0Pin = 1'b0; ext1Pin = 1'b0; tmr0Ovf = 1'b1; tmr1Ovf = 1'b1; rxDone = 1'b1; cycle();
    ext0Pin = 1'b1; ext1Pin = 1'b1; tmr0Ovf = 1'b0; tmr1Ovf = 1'b0; cycle();
    chk("R12 all flags pending", 32'(pendFlags), 32'h1F);
    globalEn = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cycle();
      chk("R4 polling order strobe", 32'(vecStrobe), 1);
      chk("R4 polling order vector", 32'(vecAddr), 32'(3 + 8 * i));
      if (i == 4) chk("R12 serial flag not cleared", 32'(pendFlags[4]), 1);
      retOnce();
      chk("R13 no vector during return", 32'(vecStrobe), 0);
    end
    rxDone = 1'b0;

    // R6 R7 R8: nesting
    settle();
    srcHigh = 5'b01000; globalEn = 1'b1;
    tmr0Ovf = 1'b1; cycle(); tmr0Ovf = 1'b0; cycle();
    chk("R5 low routine vector", 32'(vecAddr), 32'h000B);
    ext0Pin = 1'b0; cycle(); ext0Pin = 1'b1; cycle();
    chk("R7 low waits behind low", 32'(vecStrobe), 0);
    chk("R7 waiting flag kept", 32'(pendFlags[0]), 1);
    tmr1Ovf = 1'b1; cycle(); tmr1Ovf = 1'b0; cycle();
    chk("R6 high preempts strobe", 32'(vecStrobe), 1);
    chk("R6 high preempts vector", 32'(vecAddr), 32'h001B);
    chk("R6 both levels active", 32'(activeLvl), 3);
    retOnce();
    chk("R8 high cleared first", 32'(activeLvl), 1);
    cycle();
    chk("R7 still waiting under low", 32'(vecStrobe), 0);
    retOnce();
    chk("R8 low cleared", 32'(activeLvl), 0);
    cycle();
    chk("R4 queued request served", 32'(vecAddr), 32'h0003);
    retOnce();

    // R3: per-source mask
    settle();
    globalEn = 1'b1; srcEn = 5'b11101;
    tmr0Ovf = 1'b1; cycle(); tmr0Ovf = 1'b0; cycle(); cycle();
    chk("R3 masked source not vectored", 32'(vecStrobe), 0);
    chk("R3 masked flag kept", 32'(pendFlags[1]), 1);
    srcEn = 5'h1F; cycle();
    chk("R3 unmasked source vectored", 32'(vecAddr), 32'h000B);
    retOnce();

    // R10: level mode
    settle();
    globalEn = 1'b1; ext1Edge = 1'b0; ext1Pin = 1'b0; cycle();
    chk("R10 level flag follows pin", 32'(pendFlags[2]), 1);
    cycle();
    chk("R10 level source vector", 32'(vecAddr), 32'h0013);
    chk("R10 level flag not cleared", 32'(pendFlags[2]), 1);
    ext1Pin = 1'b1; cycle();
    chk("R10 level flag drops with pin", 32'(pendFlags[2]), 0);
    retOnce();

    // R9: edge latch
    settle();
    globalEn = 1'b1; srcEn = 5'b11110; ext0Pin = 1'b0; cycle(); ext0Pin = 1'b1;
    repeat (3) cycle();
    chk("R9 edge flag latched", 32'(pendFlags[0]), 1);
    srcEn = 5'h1F; cycle();
    chk("R9 edge source vectored", 32'(vecAddr), 32'h0003);
    chk("R9 edge flag cleared", 32'(pendFlags[0]), 0);
    retOnce();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      globalEn = ($urandom % 8) != 0;
      srcEn    = 5'($urandom);
      srcHigh  = 5'($urandom);
      ext0Pin  = ($urandom % 4) != 0;
      ext1Pin  = ($urandom % 4) != 0;
      ext0Edge = ($urandom % 3) != 0;
      ext1Edge = ($urandom % 3) != 0;
      tmr0Ovf  = ($urandom % 6) == 0;
      tmr1Ovf  = ($urandom % 6) == 0;
      rxDone   = ($urandom % 10) == 0;
      txDone   = ($urandom % 10) == 0;
      retPulse = ($urandom % 5) == 0;
      cycle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule